// File: doc/BRIEF.md
# Absolute-Value Exception Flag Unit

This execution unit takes one IEEE-754 single-precision operand. It returns the exception flags that taking that operand's absolute value would raise, as a 32-bit integer word. It does not produce the absolute value. It only classifies the operand and packs the flags into a fixed status-word layout. The flags are returned as data, and no architectural status is touched.

Each issued operation carries a guard word and a destination tag. Bit 0 of the guard decides whether a write takes place. The guard bit and the tag travel down the pipeline beside the operand, so the write strobe, the tag and the flag word all leave the unit together, a fixed number of cycles after issue. The unit accepts one new operation on every clock.

Top module: `fabsflg_unit`

## Requirements
- R1: A denormal operand (exponent field 8'h00, mantissa nonzero) of either sign yields the flag word 32'h20, which is bit 5, the input-flushed flag.
- R2: A signalling NaN (exponent 8'hFF, mantissa bit 22 clear, mantissa nonzero) yields 32'h10, which is bit 4, the invalid flag. A quiet NaN (exponent 8'hFF, mantissa bit 22 set) yields 32'h0.
- R3: Normal finite values, zeros and infinities of either sign yield 32'h0.
- R4: Bits 31 to 7 of the result are always zero, and at most one flag bit is set. The layout is bit 6 output flush, bit 5 input flush, bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 inexact and bit 0 divide-by-zero.
- R5: `wr_en` and the result appear exactly 3 rising edges after the edge that samples the issue. Counting that edge as the first, they are visible after the third edge and not before.
- R6: When `in_guard[0]` is 0, no write occurs. Bits 31 to 1 of `in_guard` have no effect.
- R7: A new operation can be issued on every cycle, and each result leaves with the `in_dest` tag it was issued with.
- R8: A synchronous active-high `rst` discards every operation in flight, so `wr_en` stays 0 after reset until new work is issued.
- R9: While `wr_en` is 0, `wr_data` and `wr_tag` are both zero.
- R10: A cycle with `in_valid` low produces no write, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe |
| in_operand | input | 32 | Single-precision operand |
| in_guard | input | 32 | Guard word; only bit 0 is used |
| in_dest | input | TAG_W (5) | Destination tag |
| wr_en | output | 1 | Destination write enable |
| wr_tag | output | TAG_W (5) | Destination tag of the result |
| wr_data | output | 32 | Flag word |

## Verification
A wrong stage count or a lost valid bit would show up as `wr_en` rising one edge early or late, or not at all. The bench catches this on the first operation it issues, because it samples every cycle around the expected edge. A tag or guard slipping against its operand would pair a flag word with the wrong tag or strobe. Back-to-back streams with mixed guards expose this within three cycles. A misclassified exponent or mantissa test shows up as a wrong flag word on the boundary operands: the smallest and largest denormals, the quiet/signalling split at mantissa bit 22, and the infinities.

// File: rtl/fabsflg_pkg.sv
package fabsflg_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned FLAG_W = 7;

  // Bit positions of the status-word layout
  localparam int unsigned FB_DIV0     = 0;
  localparam int unsigned FB_INEXACT  = 1;
  localparam int unsigned FB_UNDER    = 2;
  localparam int unsigned FB_OVER     = 3;
  localparam int unsigned FB_INVALID  = 4;
  localparam int unsigned FB_IN_FLUSH = 5;
  localparam int unsigned FB_OUT_FLSH = 6;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_DENORM,
    CLS_NORMAL,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } fclass_e;

  // Classify a single-precision bit pattern (sign ignored)
  function automatic fclass_e classify(input logic [7:0] expo, input logic [22:0] mant);
    if (expo == 8'h00)      return (mant == '0) ? CLS_ZERO : CLS_DENORM;
    else if (expo != 8'hFF) return CLS_NORMAL;
    else if (mant == '0)    return CLS_INF;
    else if (mant[22])      return CLS_QNAN;
    else                    return CLS_SNAN;
  endfunction

  // Flags raised by an absolute-value operation for a given class
  function automatic logic [FLAG_W-1:0] abs_flags(input fclass_e cls);
    logic [FLAG_W-1:0] f;
    f = '0;
    case (cls)
      CLS_DENORM: f[FB_IN_FLUSH] = 1'b1;
      CLS_SNAN:   f[FB_INVALID]  = 1'b1;
      default:    f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/fabsflg_classify.sv
module fabsflg_classify
  import fabsflg_pkg::*;
(
  input  logic [WORD_W-1:0] operand,
  output fclass_e           cls,
  output logic [FLAG_W-1:0] flags
);
  logic unused_sign;
  assign unused_sign = operand[31];

  always_comb begin
    cls   = classify(operand[30:23], operand[22:0]);
    flags = abs_flags(cls);
  end
endmodule

// File: rtl/fabsflg_delay.sv
module fabsflg_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < int'(DEPTH); i++) stg[i] <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < int'(DEPTH); i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/fabsflg_unit.sv
module fabsflg_unit
  import fabsflg_pkg::*;
#(
  parameter int unsigned TAG_W   = 5,
  parameter int unsigned LATENCY = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [WORD_W-1:0]    in_operand,
  input  logic [WORD_W-1:0]    in_guard,
  input  logic [TAG_W-1:0]     in_dest,
  output logic                 wr_en,
  output logic [TAG_W-1:0]     wr_tag,
  output logic [WORD_W-1:0]    wr_data
);
  localparam int unsigned TAIL  = LATENCY - 1;
  localparam int unsigned PKT_W = 1 + TAG_W + FLAG_W;

  // Named events for the checker
  logic              issue_fire;
  logic              a_vld;
  logic [TAG_W-1:0]  a_tag;
  logic [WORD_W-1:0] a_op;
  fclass_e           a_cls;
  logic [FLAG_W-1:0] flag_raw;
  logic [PKT_W-1:0]  pkt_in, pkt_out;
  logic              o_vld;
  logic [TAG_W-1:0]  o_tag;
  logic [FLAG_W-1:0] o_flags;
  logic [WORD_W-2:0] unused_guard_hi;

  assign unused_guard_hi = in_guard[WORD_W-1:1];
  assign issue_fire      = in_valid & in_guard[0];

  // Stage 1: capture operand, guarded valid and tag
  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld <= 1'b0;
      a_tag <= '0;
      a_op  <= '0;
    end else begin
      a_vld <= issue_fire;
      a_tag <= issue_fire ? in_dest : '0;
      a_op  <= in_operand;
    end
  end

  fabsflg_classify u_cls (
    .operand (a_op),
    .cls     (a_cls),
    .flags   (flag_raw)
  );

  assign pkt_in = {a_vld, a_tag, a_vld ? flag_raw : {FLAG_W{1'b0}}};

  // Remaining stages carry valid, tag and flags in lockstep
  fabsflg_delay #(.W(PKT_W), .DEPTH(TAIL)) u_tail (
    .clk (clk),
    .rst (rst),
    .d   (pkt_in),
    .q   (pkt_out)
  );

  assign {o_vld, o_tag, o_flags} = pkt_out;

  assign wr_en   = o_vld;
  assign wr_tag  = o_vld ? o_tag : '0;
  assign wr_data = o_vld ? {{(WORD_W-FLAG_W){1'b0}}, o_flags} : '0;
endmodule

// File: rtl/fabsflg_chk.sv
module fabsflg_chk
  import fabsflg_pkg::*;
#(
  parameter int unsigned TAG_W   = 5,
  parameter int unsigned LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_fire,
  input  logic [TAG_W-1:0]  in_dest,
  input  logic              a_vld,
  input  logic [FLAG_W-1:0] flag_raw,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [WORD_W-1:0] wr_data
);
  logic             vh [LATENCY];
  logic [TAG_W-1:0] th [LATENCY];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(LATENCY); i++) begin
        vh[i] <= 1'b0;
        th[i] <= '0;
      end
    end else begin
      vh[0] <= issue_fire;
      th[0] <= in_dest;
      for (int i = 1; i < int'(LATENCY); i++) begin
        vh[i] <= vh[i-1];
        th[i] <= th[i-1];
      end
    end
  end

  AST_WRITE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    wr_en == vh[LATENCY-1]);                                             // R5
  AST_TAG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_tag == th[LATENCY-1]);                                  // R7
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    wr_data[WORD_W-1:FLAG_W] == '0);                                     // R4
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_data) && $onehot0(flag_raw));                            // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (wr_data == '0 && wr_tag == '0));                         // R9
  AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !a_vld);                                              // R8
endmodule

bind fabsflg_unit fabsflg_chk #(.TAG_W(TAG_W), .LATENCY(LATENCY)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .issue_fire (issue_fire),
  .in_dest    (in_dest),
  .a_vld      (a_vld),
  .flag_raw   (flag_raw),
  .wr_en      (wr_en),
  .wr_tag     (wr_tag),
  .wr_data    (wr_data)
);

// File: tb/tb_fabsflg_unit.sv
module tb_fabsflg_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  TAG_W      = 5;
  localparam int  LAT        = 3;
  localparam int  MAXN       = 16;
  localparam int  WATCHDOG   = 20000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [31:0]       in_operand = '0;
  logic [31:0]       in_guard = '0;
  logic [TAG_W-1:0]  in_dest = '0;
  logic              wr_en;
  logic [TAG_W-1:0]  wr_tag;
  logic [31:0]       wr_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  logic [31:0]      s_op  [MAXN];
  logic [31:0]      s_gd  [MAXN];
  logic [TAG_W-1:0] s_tag [MAXN];
  logic             s_vld [MAXN];

  fabsflg_unit #(.TAG_W(TAG_W), .LATENCY(LAT)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .in_guard(in_guard), .in_dest(in_dest), .wr_en(wr_en),
    .wr_tag(wr_tag), .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
      summary();
    end
  end

  function automatic void summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endfunction

  // Expected flag word, written from the requirement text
  function automatic logic [31:0] ref_flags(input logic [31:0] v);
    logic [7:0]  e;
    logic [22:0] m;
    e = v[30:23];
    m = v[22:0];
    if (e == 8'd0 && m != 0)                 return 32'h20;  // R1
    if (e == 8'd255 && m != 0 && m[22] == 0) return 32'h10;  // R2
    return 32'h0;                                             // R2 / R3
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue n operations on consecutive cycles and check every output cycle
  task automatic run_seq(input string req, input int n);
    for (int k = 0; k < n + LAT + 1; k++) begin
      @(negedge clk);
      if (k >= LAT && k - LAT < n) begin
        automatic int j = k - LAT;
        automatic logic we = s_vld[j] & s_gd[j][0];
        chk({req, " wr_en"}, 64'(wr_en), 64'(we));
        chk({req, " wr_data"}, 64'(wr_data), we ? 64'(ref_flags(s_op[j])) : 64'h0);
        chk({req, " wr_tag"}, 64'(wr_tag), we ? 64'(s_tag[j]) : 64'h0);
      end else begin
        chk({req, " idle wr_en"}, 64'(wr_en), 64'h0);
      end
      if (k < n) begin
        in_valid   = s_vld[k];
        in_operand = s_op[k];
        in_guard   = s_gd[k];
        in_dest    = s_tag[k];
      end else begin
        in_valid = 0; in_operand = '0; in_guard = '0; in_dest = '0;
      end
    end
  endtask

  task automatic set_item(input int i, input logic [31:0] op, input logic [31:0] gd,
                          input logic [TAG_W-1:0] tg, input logic v);
    s_op[i] = op; s_gd[i] = gd; s_tag[i] = tg; s_vld[i] = v;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R8 reset wr_en", 64'(wr_en), 64'h0);
    chk("R9 reset wr_data", 64'(wr_data), 64'h0);
    chk("R9 reset wr_tag", 64'(wr_tag), 64'h0);
    rst = 0;
  endtask

  task automatic t_denormals();   // R1
    set_item(0, 32'h00400000, 32'h1, 5'd3, 1);
    set_item(1, 32'h80000001, 32'h1, 5'd4, 1);
    set_item(2, 32'h007fffff, 32'h1, 5'd5, 1);
    run_seq("R1", 3);
  endtask

  task automatic t_nans();        // R2
    set_item(0, 32'hffbfffff, 32'h1, 5'd6, 1);
    set_item(1, 32'hffffffff, 32'h1, 5'd7, 1);
    set_item(2, 32'h7f800001, 32'h1, 5'd8, 1);
    set_item(3, 32'h7fc00000, 32'h1, 5'd9, 1);
    run_seq("R2", 4);
  endtask

  task automatic t_quiet_values(); // R3, R4
    set_item(0, 32'h40400000, 32'h1, 5'd10, 1);
    set_item(1, 32'hbf800000, 32'h1, 5'd11, 1);
    set_item(2, 32'hff7fffff, 32'h1, 5'd12, 1);
    set_item(3, 32'h00000000, 32'h1, 5'd13, 1);
    set_item(4, 32'h80000000, 32'h1, 5'd14, 1);
    set_item(5, 32'h7f800000, 32'h1, 5'd15, 1);
    set_item(6, 32'hff800000, 32'h1, 5'd16, 1);
    set_item(7, 32'h00800000, 32'h1, 5'd17, 1);
    run_seq("R3 R4", 8);
  endtask

  task automatic t_latency();     // R5: no early or late strobe
    set_item(0, 32'h00000001, 32'h1, 5'd21, 1);
    run_seq("R5", 1);
  endtask

  task automatic t_guard();       // R6, R10
    set_item(0, 32'h00400000, 32'h0, 5'd1, 1);
    set_item(1, 32'hffbfffff, 32'hfffffffe, 5'd2, 1);
    set_item(2, 32'h00400000, 32'h80000001, 5'd3, 1);
    set_item(3, 32'hffbfffff, 32'h1, 5'd4, 0);
    set_item(4, 32'hffbfffff, 32'h3, 5'd5, 1);
    run_seq("R6 R10", 5);
  endtask

  task automatic t_stream();      // R7
    for (int i = 0; i < 12; i++)
      set_item(i, (i % 3 == 0) ? 32'h00000010 : (i % 3 == 1) ? 32'h7fa00000 : 32'h3f800000,
               32'(i % 5 != 4), 5'(i + 7), 1);
    run_seq("R7", 12);
  endtask

  task automatic t_reset_flight(); // R8
    @(negedge clk);
    in_valid = 1; in_operand = 32'h00400000; in_guard = 32'h1; in_dest = 5'd30;
    @(negedge clk);
    in_valid = 1; in_operand = 32'hffbfffff; in_dest = 5'd31;
    rst = 1;
    @(negedge clk);
    rst = 0; in_valid = 0; in_guard = '0; in_dest = '0; in_operand = '0;
    for (int k = 0; k < 5; k++) begin
      chk("R8 flushed wr_en", 64'(wr_en), 64'h0);
      @(negedge clk);
    end
  endtask

  initial begin
    t_reset_state();
    t_latency();
    t_denormals();
    t_nans();
    t_quiet_values();
    t_guard();
    t_stream();
    t_reset_flight();
    t_latency();
    summary();
  end
endmodule